// File: doc/BRIEF.md
# Asynchronous Parallel NOR Flash Host Controller

This block sits on the host side of an asynchronous parallel NOR flash. It turns single word requests from a synchronous valid/ready port into chip-enable, output-enable and write-enable waveforms, a word address and a 16-bit data bus. Every delay the memory needs is a clock-cycle count given by a parameter. A read returns its data together with a one-cycle done pulse. A write uses a write-enable pulse that sits inside a longer chip-enable window.

The controller keeps the device selected between requests, which lets it use page mode. A page is a group of 2^PAGE_BITS words (16 by default) selected by the low address bits. After a read, another read that keeps the upper address bits and changes only the low bits waits only the short in-page delay. Any other read pays the full random delay. The device starts a new access only on an address change. So when a request repeats the last address while the chip is still selected, the controller first deselects it for a few cycles. If no request arrives for a programmed number of cycles, the chip is deselected so that it drops to standby.

Top module: `nor_page_ctrl`

## Requirements
- R1: After reset, chip-enable, output-enable and write-enable are high (inactive), the data bus is not driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read starting from a deselected chip holds chip-enable low with output-enable high for T_ASU cycles, then output-enable low for T_RACC cycles. It samples the data bus in the last of those cycles and pulses `rsp_valid` for one cycle on the next cycle with that word on `rsp_rdata`.
- R3: After a completed read, while chip-enable and output-enable are still low, a read whose address matches in bits AW-1..PAGE_BITS and differs in bits PAGE_BITS-1..0 keeps both strobes low and completes after T_PACC cycles, so `rsp_valid` comes T_PACC+1 cycles after acceptance.
- R4: A read to a different page while the chip is selected takes the full path of R2: output-enable high for T_ASU cycles, then T_RACC cycles.
- R5: A request (read or write) to the same address as the last access while chip-enable is low first raises chip-enable for T_REL cycles, then runs the full read or write sequence.
- R6: A write holds chip-enable low and output-enable high for T_WSU cycles, drives write-enable low for T_WP cycles, then keeps chip-enable low for T_WH cycles with write-enable high. Output-enable and write-enable are never low together.
- R7: The data bus is driven only while output-enable is high. The written word is driven and unchanged on the cycle write-enable rises.
- R8: A read after a write never uses the page delay, even within the same page: it takes T_ASU+T_RACC cycles.
- R9: With no request pending, chip-enable and output-enable return high on the T_IDLE-th cycle after the chip goes idle. The next read then takes the full random path of R2.
- R10: `req_ready` is high only while the controller is idle, so only one request is outstanding; it is low on the first cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_valid |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_addr | output | AW | Word address to the memory |
| flash_dq_out | output | DW | Data toward the memory |
| flash_dq_oe | output | 1 | Host drives the data bus when 1 |
| flash_dq_in | input | DW | Data from the memory |

## Verification
The bench issues reads in four patterns and tells them apart by latency and by how many cycles each strobe spends high. The patterns are: a cold read from a deselected chip, in-page reads that change only the low nibble, a read to another page with the chip selected, and a read that repeats the last address. Writes are issued after a read, after a write, and to the last address, which separates the plain setup from the deselect-first path and checks the data still held at the write-enable rise. A read after a write in the same page and a read after the idle timeout show that the page shortcut is taken only while a read session is still open.

// File: rtl/nor_ctrl_pkg.sv
package nor_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_HOLD,
      ST_RELEASE
   } nor_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R2: every wait state shortens by exactly one cycle per clock
   a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nor_addr_track.sv
module nor_addr_track #(
   parameter int AW        = 20,
   parameter int PAGE_BITS = 4,
   parameter bit PAGE_MODE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_q,
   output logic          same_word,
   output logic          same_page
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
      end
   end

   assign same_word = (addr_q == addr_in);

   generate
      if (PAGE_MODE) begin : g_page
         assign same_page = (addr_q[AW-1:PAGE_BITS] == addr_in[AW-1:PAGE_BITS]);
      end else begin : g_nopage
         assign same_page = 1'b0;
      end
   endgenerate

   // R5: the presented address only moves when a request is taken
   a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(addr_q));

endmodule

// File: rtl/nor_page_ctrl.sv
module nor_page_ctrl
   import nor_ctrl_pkg::*;
#(
   parameter int AW        = 20,
   parameter int DW        = 16,
   parameter int PAGE_BITS = 4,
   parameter bit PAGE_MODE = 1'b1,
   parameter int T_ASU     = 2,
   parameter int T_RACC    = 6,
   parameter int T_PACC    = 2,
   parameter int T_WSU     = 2,
   parameter int T_WP      = 3,
   parameter int T_WH      = 1,
   parameter int T_REL     = 2,
   parameter int T_IDLE    = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          flash_ce_n,
   output logic          flash_oe_n,
   output logic          flash_we_n,
   output logic [AW-1:0] flash_addr,
   output logic [DW-1:0] flash_dq_out,
   output logic          flash_dq_oe,
   input  logic [DW-1:0] flash_dq_in
);

   localparam int T_MAX = max2(max2(max2(T_ASU, T_RACC), max2(T_PACC, T_WSU)),
                               max2(max2(T_WP, T_WH), T_REL));
   localparam int CW    = $clog2(T_MAX + 1);
   localparam int IW    = $clog2(T_IDLE + 1);

   generate
      if (T_ASU < 1 || T_RACC < 1 || T_PACC < 1 || T_WSU < 1 ||
          T_WP < 1 || T_WH < 1 || T_REL < 1 || T_IDLE < 1) begin : g_bad_cycles
         $error("nor_page_ctrl: every cycle count must be at least 1");
      end
      if (T_PACC > T_RACC) begin : g_bad_page
         $error("nor_page_ctrl: page delay exceeds random delay");
      end
      if (PAGE_BITS < 1 || PAGE_BITS >= AW) begin : g_bad_pagebits
         $error("nor_page_ctrl: PAGE_BITS out of range");
      end
      if (DW < 1) begin : g_bad_dw
         $error("nor_page_ctrl: DW must be positive");
      end
   endgenerate

   nor_state_e    state_q, state_d;
   logic          tmr_load;
   logic [CW-1:0] tmr_val;
   logic          tmr_done;
   logic          accept;
   logic          same_word, same_page;
   logic          sess_open_q;
   logic          rd_open_q;
   logic          pend_wr_q;
   logic [DW-1:0] wdata_q;
   logic [IW-1:0] idle_cnt_q;
   logic          idle_expire;
   logic          rd_finish;

   nor_wait_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   nor_addr_track #(
      .AW        (AW),
      .PAGE_BITS (PAGE_BITS),
      .PAGE_MODE (PAGE_MODE)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .addr_in   (req_addr),
      .addr_q    (flash_addr),
      .same_word (same_word),
      .same_page (same_page)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign rd_finish = (state_q == ST_RD_WAIT) && tmr_done;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (sess_open_q && same_word) begin
                  state_d = ST_RELEASE;
                  tmr_val = CW'(T_REL - 1);
               end else if (!req_write && rd_open_q && same_page) begin
                  state_d = ST_RD_WAIT;
                  tmr_val = CW'(T_PACC - 1);
               end else if (req_write) begin
                  state_d = ST_WR_SETUP;
                  tmr_val = CW'(T_WSU - 1);
               end else begin
                  state_d = ST_RD_SETUP;
                  tmr_val = CW'(T_ASU - 1);
               end
            end
         end
         ST_RD_SETUP: begin
            if (tmr_done) begin
               state_d  = ST_RD_WAIT;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_RACC - 1);
            end
         end
         ST_RD_WAIT: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         ST_WR_SETUP: begin
            if (tmr_done) begin
               state_d  = ST_WR_PULSE;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_WP - 1);
            end
         end
         ST_WR_PULSE: begin
            if (tmr_done) begin
               state_d  = ST_WR_HOLD;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_WH - 1);
            end
         end
         ST_WR_HOLD: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         ST_RELEASE: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               if (pend_wr_q) begin
                  state_d = ST_WR_SETUP;
                  tmr_val = CW'(T_WSU - 1);
               end else begin
                  state_d = ST_RD_SETUP;
                  tmr_val = CW'(T_ASU - 1);
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign idle_expire = (state_q == ST_IDLE) && !req_valid && sess_open_q &&
                        (idle_cnt_q == IW'(T_IDLE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sess_open_q <= 1'b0;
         rd_open_q   <= 1'b0;
         pend_wr_q   <= 1'b0;
         wdata_q     <= '0;
         idle_cnt_q  <= '0;
         rsp_valid   <= 1'b0;
         rsp_rdata   <= '0;
      end else begin
         state_q   <= state_d;
         rsp_valid <= rd_finish;
         if (rd_finish) rsp_rdata <= flash_dq_in;

         if (accept) begin
            pend_wr_q <= req_write;
            wdata_q   <= req_wdata;
         end

         if (state_d == ST_RELEASE || idle_expire) begin
            sess_open_q <= 1'b0;
         end else if (state_d == ST_RD_SETUP || state_d == ST_WR_SETUP) begin
            sess_open_q <= 1'b1;
         end

         if (accept || idle_expire) begin
            rd_open_q <= 1'b0;
         end else if (rd_finish) begin
            rd_open_q <= 1'b1;
         end

         if (state_q != ST_IDLE || req_valid || !sess_open_q || idle_expire) begin
            idle_cnt_q <= '0;
         end else begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      flash_ce_n  = 1'b0;
      flash_oe_n  = 1'b1;
      flash_we_n  = 1'b1;
      flash_dq_oe = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            flash_ce_n = !sess_open_q;
            flash_oe_n = !rd_open_q;
         end
         ST_RD_WAIT:  flash_oe_n = 1'b0;
         ST_WR_PULSE: begin
            flash_we_n  = 1'b0;
            flash_dq_oe = 1'b1;
         end
         ST_WR_HOLD:  flash_dq_oe = 1'b1;
         ST_RELEASE:  flash_ce_n = 1'b1;
         default: ;
      endcase
   end

   assign flash_dq_out = wdata_q;

   // R6: read strobe and write strobe never overlap
   a_r6_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!flash_oe_n && !flash_we_n));

   // R6: chip selected on the cycle before and the cycle of the write-enable fall
   a_r6_ce_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flash_we_n) |-> (!flash_ce_n && !$past(flash_ce_n)));

   // R6: chip still selected as write-enable rises
   a_r6_ce_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_we_n) |-> !flash_ce_n);

   // R7: data driven and unchanged across the write-enable rise
   a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flash_we_n) |-> (flash_dq_oe && $stable(flash_dq_out)));

   // R7: host never drives while the memory may drive
   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      flash_dq_oe |-> flash_oe_n);

   // R5: a repeated address with the chip selected deselects it next cycle
   a_r5_repeat_deselects: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !flash_ce_n && req_addr == flash_addr) |=> flash_ce_n);

   // R2: done is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R10: no acceptance on the cycle after one was taken
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/nor_page_ctrl_tb_top.sv
module nor_page_ctrl_tb_top;

   localparam int AW     = 20;
   localparam int DW     = 16;
   localparam int T_ASU  = 2;
   localparam int T_RACC = 6;
   localparam int T_PACC = 2;
   localparam int T_WSU  = 2;
   localparam int T_WP   = 3;
   localparam int T_WH   = 1;
   localparam int T_REL  = 2;
   localparam int T_IDLE = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe;
   logic [AW-1:0] flash_addr;
   logic [DW-1:0] flash_dq_out;
   logic [DW-1:0] flash_dq_in;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   assign flash_dq_in = flash_oe_n ? 16'hDEAD : pat(flash_addr);

   nor_page_ctrl #(
      .AW(AW), .DW(DW), .PAGE_BITS(4), .PAGE_MODE(1'b1),
      .T_ASU(T_ASU), .T_RACC(T_RACC), .T_PACC(T_PACC), .T_WSU(T_WSU),
      .T_WP(T_WP), .T_WH(T_WH), .T_REL(T_REL), .T_IDLE(T_IDLE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n),
      .flash_addr(flash_addr), .flash_dq_out(flash_dq_out),
      .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // Issues one request and records what the strobes did until it completes.
   task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int lat, output int ce_hi, output int oe_hi,
                         output int we_lo, output int setup_n, output int rd,
                         output int viol, output int hold_ok, output int rdy1);
      bit seen_we = 0;
      bit prev_we_lo = 0;
      lat = -1; ce_hi = 0; oe_hi = 0; we_lo = 0; setup_n = 0; rd = -1;
      viol = 0; hold_ok = 0; rdy1 = -1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k < 100; k++) begin
         if (k > 1) @(negedge clk);
         if (k == 1) rdy1 = req_ready;
         if (flash_ce_n) ce_hi++;
         if (flash_oe_n) oe_hi++;
         if (!flash_we_n) we_lo++;
         if (!flash_oe_n && !flash_we_n) viol++;
         if (flash_dq_oe && !flash_oe_n) viol++;
         if (!seen_we && flash_we_n && !flash_ce_n && wr) setup_n++;
         if (!flash_we_n) seen_we = 1;
         if (prev_we_lo && flash_we_n)
            hold_ok = (flash_dq_oe && flash_dq_out == d && !flash_ce_n) ? 1 : 0;
         prev_we_lo = !flash_we_n;
         if (!wr && rsp_valid) begin
            lat = k; rd = int'(rsp_rdata); break;
         end
         if (wr && k > 1 && req_ready) begin
            lat = k; break;
         end
      end
   endtask

   int lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1;

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "ce_n", int'(flash_ce_n), 1);
      chk("R1", "oe_n", int'(flash_oe_n), 1);
      chk("R1", "we_n", int'(flash_we_n), 1);
      chk("R1", "dq_oe", int'(flash_dq_oe), 0);
      chk("R1", "ready", int'(req_ready), 1);
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
   endtask

   task automatic t_cold_read();
      run_op(0, 20'h01230, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R2", "cold latency", lat, T_ASU + T_RACC + 1);
      chk("R2", "cold data", rd, int'(pat(20'h01230)));
      chk("R2", "cold oe high cycles", oe_hi, T_ASU);
      chk("R2", "cold ce high cycles", ce_hi, 0);
      chk("R10", "ready after accept", rdy1, 0);
   endtask

   task automatic t_page_reads();
      run_op(0, 20'h01235, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R3", "page latency", lat, T_PACC + 1);
      chk("R3", "page data", rd, int'(pat(20'h01235)));
      chk("R3", "page oe high cycles", oe_hi, 0);
      chk("R3", "page ce high cycles", ce_hi, 0);
      run_op(0, 20'h0123F, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R3", "page latency 2", lat, T_PACC + 1);
      chk("R3", "page data 2", rd, int'(pat(20'h0123F)));
   endtask

   task automatic t_other_page();
      run_op(0, 20'h04567, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R4", "new page latency", lat, T_ASU + T_RACC + 1);
      chk("R4", "new page oe high cycles", oe_hi, T_ASU);
      chk("R4", "new page ce high cycles", ce_hi, 0);
      chk("R4", "new page data", rd, int'(pat(20'h04567)));
   endtask

   task automatic t_repeat_read();
      run_op(0, 20'h04567, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R5", "repeat latency", lat, T_REL + T_ASU + T_RACC + 1);
      chk("R5", "repeat ce high cycles", ce_hi, T_REL);
      chk("R5", "repeat oe high cycles", oe_hi, T_REL + T_ASU);
      chk("R5", "repeat data", rd, int'(pat(20'h04567)));
   endtask

   task automatic t_write_after_read();
      run_op(1, 20'h04568, 16'hBEEF, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R6", "write setup cycles", setup_n, T_WSU);
      chk("R6", "write pulse cycles", we_lo, T_WP);
      chk("R6", "write total cycles", lat, T_WSU + T_WP + T_WH + 1);
      chk("R6", "strobe overlap or contention", viol, 0);
      chk("R7", "data held at we rise", hold_ok, 1);
      chk("R6", "write ce high cycles", ce_hi, 0);
   endtask

   task automatic t_read_after_write();
      run_op(0, 20'h04569, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R8", "read after write latency", lat, T_ASU + T_RACC + 1);
      chk("R8", "read after write data", rd, int'(pat(20'h04569)));
   endtask

   task automatic t_idle_timeout();
      int n = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         n++;
         if (flash_ce_n) break;
      end
      chk("R9", "cycles to deselect", n, T_IDLE);
      chk("R9", "oe released", int'(flash_oe_n), 1);
      run_op(0, 20'h0456A, '0, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R9", "read after standby latency", lat, T_ASU + T_RACC + 1);
      chk("R9", "read after standby data", rd, int'(pat(20'h0456A)));
   endtask

   task automatic t_repeat_write();
      run_op(1, 20'h0456A, 16'h1357, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R5", "repeat write ce high cycles", ce_hi, T_REL);
      chk("R5", "repeat write total cycles", lat, T_REL + T_WSU + T_WP + T_WH + 1);
      chk("R7", "repeat write data held", hold_ok, 1);
      chk("R6", "repeat write setup cycles", setup_n, T_WSU);
   endtask

   task automatic t_write_after_write();
      run_op(1, 20'h0456B, 16'h2468, lat, ce_hi, oe_hi, we_lo, setup_n, rd, viol, hold_ok, rdy1);
      chk("R6", "back to back write total", lat, T_WSU + T_WP + T_WH + 1);
      chk("R6", "back to back write ce high", ce_hi, 0);
      chk("R7", "back to back data held", hold_ok, 1);
      chk("R6", "back to back no overlap", viol, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold_read();
      t_page_reads();
      t_other_page();
      t_repeat_read();
      t_write_after_read();
      t_read_after_write();
      t_idle_timeout();
      t_repeat_write();
      t_write_after_write();
      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

endmodule